// File: doc/BRIEF.md
# Power-Fail Bus Lockout Controller

This block guards the host register port of a battery-backed timekeeping device. A host reaches the register file through an active-low chip select, an active-low read and an active-low write, plus a five-bit register address and eight-bit write data. The block passes these through as gated register strobes. It also drives the enable for the data-bus output drivers.

An external detector drives the active-low power-fail input low when main power sags. The block does not lock out at once. It counts rising edges of a slow timebase tick, two by default or a programmed count when one is given, while the input stays low. Only then does it shut the host port. A bus cycle that is still running at that moment is allowed to finish first. The read drivers are released as soon as power failure is seen, whether or not lockout has begun.

Lockout ends when power is back and the bus is idle. Access then restarts only after chip select has been seen high. A lockout flag is exported so that neighbouring logic can raise a power-fail interrupt.

Top module: `pwrguard_top`

## Requirements
- R1: After reset `locked`, `reg_rd_stb`, `reg_wr_stb` and `data_oe` are 0, and `reg_addr` and `reg_wdata` are 0.
- R2: With the port open, a read strobe is given while chip select and read are both low and write is high, and a write strobe is given while chip select and write are both low. A read and a write strobe are never given together.
- R3: During a read strobe `reg_addr` carries the bus address. During a write strobe `reg_addr` and `reg_wdata` carry the bus values. Otherwise both are 0.
- R4: With no programmed delay, lockout begins after the second rising edge of `tick` counted while the synchronised power-fail input is low. It does not begin after the first.
- R5: When `dly_prog_en` is 1, the number of tick edges counted is `dly_prog_val` instead of the default.
- R6: If power-fail returns high before the count completes, the count clears and no lockout happens. A later failure needs the full count again.
- R7: While `locked` is 1, chip select, read, write, address and write data have no effect: no strobe is given and `reg_addr`/`reg_wdata` stay 0.
- R8: A read or write cycle under way when the count completes keeps its strobe until it ends. `locked` rises only after the cycle ends.
- R9: `data_oe` is 1 only during a read strobe while the synchronised power-fail input is high. It is therefore 0 whenever power-fail is low.
- R10: `locked` falls only when power-fail is high and no cycle is active. After it falls, no strobe is given until chip select has been seen high.
- R11: Power-fail, chip select, read and write pass through a two-flop synchroniser before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase, synchronous to clk; rising edges are counted |
| pwr_fail_n | input | 1 | Active-low power-fail indication, asynchronous |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 1 | Active-low read |
| bus_wr_n | input | 1 | Active-low write |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data from the host |
| dly_prog_en | input | 1 | Use the programmed tick count instead of the default |
| dly_prog_val | input | 4 | Programmed tick count |
| reg_rd_stb | output | 1 | Gated register read strobe |
| reg_wr_stb | output | 1 | Gated register write strobe |
| reg_addr | output | 5 | Gated register address |
| reg_wdata | output | 8 | Gated write data |
| data_oe | output | 1 | Enable for the data-bus output drivers |
| locked | output | 1 | Lockout in force |

## Verification
The checker tests these rules on every cycle:
- No strobe and a zeroed address and data path while locked.
- The two strobes never given together.
- The output enable only during a read strobe with power good.
- Lockout rising only after power-fail was low.
- Lockout falling only with power good and the bus idle.

The bench scenarios are needed for the rules that depend on history:
- The tick count, whether default or programmed.
- The count clearing on a power glitch.
- An in-flight cycle finishing before lockout.
- The need for a clean chip select after release.

// File: rtl/pwrguard_pkg.sv
package pwrguard_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_LOCK  = 2'd2,
        ST_REARM = 2'd3
    } guard_st_e;

    typedef struct packed {
        guard_st_e st;
    } guard_regs_t;

endpackage

// File: rtl/pwrguard_sync.sv
module pwrguard_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_in[i];
                stab_q <= meta_q;
            end
        end
        assign d_out[i] = stab_q;
    end

endmodule

// File: rtl/pwrguard_dly.sv
module pwrguard_dly #(
    parameter int CNT_W     = 4,
    parameter int DEF_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             prog_en,
    input  logic [CNT_W-1:0] prog_val,
    output logic             expired
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(DEF_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick_prev;
    } dly_regs_t;

    dly_regs_t r_q, r_d;
    logic [CNT_W-1:0] target;
    logic             tick_rise;

    always_comb begin
        target    = prog_en ? prog_val : DEF_VAL;
        tick_rise = tick && !r_q.tick_prev;
        r_d           = r_q;
        r_d.tick_prev = tick;
        if (!run) begin
            r_d.cnt = '0;
        end else if (tick_rise && r_q.cnt != CNT_MAX) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        expired = run && (r_q.cnt >= target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/pwrguard_top.sv
module pwrguard_top
    import pwrguard_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int DEF_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pwr_fail_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dly_prog_en,
    input  logic [CNT_W-1:0]  dly_prog_val,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              data_oe,
    output logic              locked
);

    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic pf_s, cs_s, rd_s, wr_s;
    logic acc_s, gate_open, expired, dly_run;
    logic rd_req, wr_req;
    guard_regs_t r_q, r_d;

    assign raw_in = {pwr_fail_n, bus_cs_n, bus_rd_n, bus_wr_n};

    // R11: two-flop synchronisers on the asynchronous controls
    pwrguard_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (syn_out)
    );

    assign pf_s = syn_out[3];
    assign cs_s = syn_out[2];
    assign rd_s = syn_out[1];
    assign wr_s = syn_out[0];

    assign acc_s   = !cs_s && (!rd_s || !wr_s);
    assign dly_run = !pf_s && (r_q.st != ST_LOCK);

    pwrguard_dly #(.CNT_W(CNT_W), .DEF_TICKS(DEF_TICKS)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (dly_run),
        .prog_en  (dly_prog_en),
        .prog_val (dly_prog_val),
        .expired  (expired)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (expired) r_d.st = acc_s ? ST_DRAIN : ST_LOCK;
            end
            ST_DRAIN: begin
                if (!acc_s) r_d.st = pf_s ? ST_RUN : ST_LOCK;
            end
            ST_LOCK: begin
                if (pf_s && !acc_s) r_d.st = ST_REARM;
            end
            ST_REARM: begin
                if (expired)   r_d.st = ST_LOCK;
                else if (cs_s) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN};
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_open = (r_q.st == ST_RUN) || (r_q.st == ST_DRAIN);
    assign rd_req    = !cs_s && !rd_s && wr_s;
    assign wr_req    = !cs_s && !wr_s;

    assign reg_rd_stb = gate_open && rd_req;
    assign reg_wr_stb = gate_open && wr_req;
    assign reg_addr   = (reg_rd_stb || reg_wr_stb) ? bus_addr : '0;
    assign reg_wdata  = reg_wr_stb ? bus_wdata : '0;
    assign data_oe    = reg_rd_stb && pf_s;
    assign locked     = (r_q.st == ST_LOCK);

endmodule

// File: rtl/pwrguard_chk.sv
module pwrguard_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_s,
    input logic              acc_s,
    input logic              reg_rd_stb,
    input logic              reg_wr_stb,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              data_oe,
    input logic              locked
);

    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!reg_rd_stb && !reg_wr_stb && reg_addr == '0 && reg_wdata == '0));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd_stb, reg_wr_stb}));

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (reg_rd_stb && pf_s));

    // R4
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!pf_s));

    // R10
    unlock_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(pf_s) && $past(!acc_s)));

    // R3
    wdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_stb |-> (reg_wdata == '0));

endmodule

bind pwrguard_top pwrguard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf_s       (pf_s),
    .acc_s      (acc_s),
    .reg_rd_stb (reg_rd_stb),
    .reg_wr_stb (reg_wr_stb),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .data_oe    (data_oe),
    .locked     (locked)
);

// File: tb/pwrguard_top_tb.sv
module pwrguard_top_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pwr_fail_n = 1'b1;
    logic       bus_cs_n = 1'b1;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       dly_prog_en = 1'b0;
    logic [3:0] dly_prog_val = '0;
    logic       reg_rd_stb, reg_wr_stb, data_oe, locked;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pwrguard_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .pwr_fail_n   (pwr_fail_n),
        .bus_cs_n     (bus_cs_n),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .dly_prog_en  (dly_prog_en),
        .dly_prog_val (dly_prog_val),
        .reg_rd_stb   (reg_rd_stb),
        .reg_wr_stb   (reg_wr_stb),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .data_oe      (data_oe),
        .locked       (locked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        wait_cyc(1);
        tick = 1'b0;
        wait_cyc(3);
    endtask

    task automatic bus_idle();
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        bus_addr = '0; bus_wdata = '0;
        wait_cyc(4);
    endtask

    task automatic power_up();
        pwr_fail_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        check("R1 locked", locked, 0);
        check("R1 rd_stb", reg_rd_stb, 0);
        check("R1 wr_stb", reg_wr_stb, 0);
        check("R1 oe", data_oe, 0);
        check("R1 addr/wdata", {reg_addr, reg_wdata}, 0);
    endtask

    task automatic t_normal();
        bus_addr = 5'h1A; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        wait_cyc(3);
        check("R2 rd strobe", reg_rd_stb, 1);
        check("R2 no wr strobe", reg_wr_stb, 0);
        check("R3 rd addr", reg_addr, 5'h1A);
        check("R9 oe on read", data_oe, 1);
        bus_rd_n = 1'b1; bus_wr_n = 1'b0; bus_addr = 5'h05; bus_wdata = 8'hC3;
        wait_cyc(3);
        check("R2 wr strobe", reg_wr_stb, 1);
        check("R3 wr addr", reg_addr, 5'h05);
        check("R3 wr data", reg_wdata, 8'hC3);
        check("R9 no oe on write", data_oe, 0);
        bus_cs_n = 1'b1;
        wait_cyc(3);
        check("R3 idle addr/data", {reg_addr, reg_wdata}, 0);
        bus_idle();
    endtask

    task automatic t_default_delay();
        pwr_fail_n = 1'b0;
        wait_cyc(4);
        pulse_tick();
        check("R4 not locked after one tick", locked, 0);
        pulse_tick();
        check("R4 locked after two ticks", locked, 1);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_addr = 5'h1F; bus_wdata = 8'hFF;
        wait_cyc(3);
        check("R7 wr ignored", reg_wr_stb, 0);
        check("R7 addr/data held 0", {reg_addr, reg_wdata}, 0);
        bus_wr_n = 1'b1; bus_rd_n = 1'b0;
        wait_cyc(3);
        check("R7 rd ignored", reg_rd_stb, 0);
        check("R9 no oe locked", data_oe, 0);
        pwr_fail_n = 1'b1;
        wait_cyc(6);
        check("R10 held while cycle active", locked, 1);
        bus_idle();
        check("R10 released", locked, 0);
    endtask

    task automatic t_glitch();
        pwr_fail_n = 1'b0;
        wait_cyc(4);
        pulse_tick();
        pwr_fail_n = 1'b1;
        wait_cyc(4);
        pulse_tick();
        check("R6 no lock after glitch", locked, 0);
        pwr_fail_n = 1'b0;
        wait_cyc(4);
        pulse_tick();
        check("R6 count restarted", locked, 0);
        pulse_tick();
        check("R6 locks after full count", locked, 1);
        power_up();
        check("R10 released idle", locked, 0);
    endtask

    task automatic t_prog();
        dly_prog_en = 1'b1; dly_prog_val = 4'd3;
        pwr_fail_n = 1'b0;
        wait_cyc(4);
        pulse_tick();
        pulse_tick();
        check("R5 not locked at default count", locked, 0);
        pulse_tick();
        check("R5 locked at programmed count", locked, 1);
        power_up();
        dly_prog_en = 1'b0; dly_prog_val = '0;
    endtask

    task automatic t_drain();
        bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_addr = 5'h09; bus_wdata = 8'h5A;
        wait_cyc(3);
        pwr_fail_n = 1'b0;
        wait_cyc(4);
        pulse_tick();
        pulse_tick();
        check("R8 not locked mid write", locked, 0);
        check("R8 write strobe kept", reg_wr_stb, 1);
        check("R8 write data kept", reg_wdata, 8'h5A);
        bus_idle();
        check("R8 locked after write ends", locked, 1);
        power_up();
        bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_addr = 5'h11;
        wait_cyc(3);
        pwr_fail_n = 1'b0;
        wait_cyc(3);
        check("R9 read strobe with pf low", reg_rd_stb, 1);
        check("R9 oe released with pf low", data_oe, 0);
        pulse_tick();
        pulse_tick();
        check("R8 read keeps port", locked, 0);
        bus_idle();
        check("R8 locked after read ends", locked, 1);
    endtask

    task automatic t_clean_cs();
        bus_cs_n = 1'b0;
        wait_cyc(3);
        pwr_fail_n = 1'b1;
        wait_cyc(6);
        check("R10 unlocked with cs idle-low", locked, 0);
        bus_rd_n = 1'b0; bus_addr = 5'h03;
        wait_cyc(3);
        check("R10 no strobe before clean cs", reg_rd_stb, 0);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        wait_cyc(4);
        bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        wait_cyc(3);
        check("R10 strobe after clean cs", reg_rd_stb, 1);
        bus_idle();
    endtask

    task automatic t_sync();
        bus_addr = 5'h02; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        wait_cyc(1);
        check("R11 one cycle: not yet", reg_rd_stb, 0);
        wait_cyc(1);
        check("R11 two cycles: visible", reg_rd_stb, 1);
        bus_idle();
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_normal();
        t_sync();
        t_default_delay();
        t_glitch();
        t_prog();
        t_drain();
        t_clean_cs();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule